// File: doc/BRIEF.md
# Store-Miss Ownership Fetch Sequencer

This controller takes over when a coherent store misses in an external cache. It accepts one miss at a time. A miss carries the line address of the store, the tag, dirty flag and contents of the line that now occupies the target index, and the store bytes with a byte-enable mask. The controller then issues system-bus requests on one valid/ready port. If the victim is dirty, it first sends a writeback that carries the victim contents. It always sends an ownership read for the store's line. It then accepts the returned line on a valid/ready fill port and overlays the enabled store bytes on it. The finished line goes out on a valid/ready cache-write port, marked as modified.

Every address on the ports is a line address, with no byte offset. The victim's line address is its tag followed by the index bits of the store address. All three streaming ports follow the same rule. A source that raises valid keeps valid and its payload unchanged until ready is seen high at a clock edge. The transfer takes place at that edge. The miss port is ready only while the controller is idle, so back-pressure on the bus, fill or cache-write port delays the acceptance of the next miss.

Top module: `wmiss_seq`

## Requirements
- R1: After reset, miss_ready is 1 and busy, bus_req_valid, fill_ready and cwr_valid are 0.
- R2: For a miss whose victim dirty flag is 1, the first bus request has bus_req_kind = 0 (writeback), address {victim tag, index of miss_line_addr} and data equal to the victim contents.
- R3: For a miss whose victim dirty flag is 0, no writeback is issued. The first bus request is the ownership read.
- R4: An ownership read (bus_req_kind = 1) with address equal to miss_line_addr is issued for every miss, and always after the writeback when there is one.
- R5: While bus_req_valid is 1 and bus_req_ready is 0, the request kind, address and data hold steady on the next cycle.
- R6: fill_ready is 1 only after the ownership read has been accepted and before a fill has been taken. A fill transfer is followed on the next cycle by cwr_valid.
- R7: In the written line, byte i (bits 8i+7 down to 8i) comes from the store data when miss_byte_en[i] is 1, and from the fill data otherwise.
- R8: The cache write carries the miss line address and line state 2'b11 (modified, valid and dirty). Its payload is held until cwr_ready is seen.
- R9: miss_ready is 0 from the cycle after a miss is accepted until the cycle after the cache write is accepted. A miss presented during that time has no effect.
- R10: An all-ones byte-enable mask writes the store line unchanged, and an all-zero mask writes the fill line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss accepted when both high |
| miss_line_addr | input | TAG_W+IDX_W | Line address of the store |
| miss_victim_tag | input | TAG_W | Tag of the line being evicted |
| miss_victim_dirty | input | 1 | Victim holds modified data |
| miss_victim_data | input | 8*LINE_BYTES | Victim line contents |
| miss_store_data | input | 8*LINE_BYTES | Store bytes, placed at their line positions |
| miss_byte_en | input | LINE_BYTES | Byte mask of the store |
| bus_req_valid | output | 1 | Bus request present |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_kind | output | 1 | 0 = writeback, 1 = ownership read |
| bus_req_addr | output | TAG_W+IDX_W | Line address of the request |
| bus_req_data | output | 8*LINE_BYTES | Victim contents (meaningful for writeback) |
| fill_valid | input | 1 | Returned line present |
| fill_ready | output | 1 | Controller takes the returned line |
| fill_data | input | 8*LINE_BYTES | Returned line |
| cwr_valid | output | 1 | Cache-array write present |
| cwr_ready | input | 1 | Cache arrays accept the write |
| cwr_line_addr | output | TAG_W+IDX_W | Line address written |
| cwr_data | output | 8*LINE_BYTES | Merged line |
| cwr_line_state | output | 2 | Line state, 2'b11 = modified |
| busy | output | 1 | A miss is in progress |

## Verification
A controller stuck in a wrong state shows up on the next clock edge. It raises the wrong valid or ready, or it holds miss_ready low once the cache write is done, and the scoreboard then sees an unexpected or missing request. A skipped or duplicated writeback appears as soon as the first bus request is accepted, because its kind or address differs from the queued item. A merge or capture error shows only at the cache-write handshake, so every line is compared there byte for byte. Random ready stalls show whether payloads stay steady under back-pressure.

// File: rtl/wmiss_pkg.sv
package wmiss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WB   = 3'd1,
    ST_RFO  = 3'd2,
    ST_FILL = 3'd3,
    ST_CWR  = 3'd4
  } wm_state_e;

  localparam logic REQ_WB  = 1'b0;
  localparam logic REQ_RFO = 1'b1;

  localparam logic [1:0] LINE_ST_MOD = 2'b11;
endpackage

// File: rtl/wmiss_ctrl.sv
module wmiss_ctrl
  import wmiss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic victim_dirty,
  input  logic bus_req_ready,
  input  logic fill_valid,
  input  logic cwr_ready,
  output logic miss_ready,
  output logic bus_req_valid,
  output logic bus_req_kind,
  output logic fill_ready,
  output logic cwr_valid,
  output logic busy,
  output logic load_miss,
  output logic load_fill
);

  wm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (miss_valid)    state_d = victim_dirty ? ST_WB : ST_RFO;
      ST_WB:   if (bus_req_ready) state_d = ST_RFO;
      ST_RFO:  if (bus_req_ready) state_d = ST_FILL;
      ST_FILL: if (fill_valid)    state_d = ST_CWR;
      ST_CWR:  if (cwr_ready)     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign miss_ready    = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign bus_req_valid = (state_q == ST_WB) || (state_q == ST_RFO);
  assign bus_req_kind  = (state_q == ST_RFO) ? REQ_RFO : REQ_WB;
  assign fill_ready    = (state_q == ST_FILL);
  assign cwr_valid     = (state_q == ST_CWR);
  assign load_miss     = miss_ready && miss_valid;
  assign load_fill     = fill_ready && fill_valid;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid && $stable(bus_req_kind)));

  // R4
  wb_then_rfo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready && bus_req_kind == REQ_WB) |=>
      (bus_req_valid && bus_req_kind == REQ_RFO));

  // R6
  rfo_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_ready && bus_req_kind == REQ_RFO) |=> fill_ready);

  // R6
  fill_to_cwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (cwr_valid && !fill_ready));

  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  // R9
  cwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && cwr_ready) |=> miss_ready);

endmodule

// File: rtl/wmiss_bytemerge.sv
module wmiss_bytemerge #(
  parameter int LINE_BYTES = 64,
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic [LINE_W-1:0]     fill_line,
  input  logic [LINE_W-1:0]     store_line,
  input  logic [LINE_BYTES-1:0] byte_en,
  output logic [LINE_W-1:0]     merged_line
);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign merged_line[8*b +: 8] = byte_en[b] ? store_line[8*b +: 8] : fill_line[8*b +: 8];
  end

endmodule

// File: rtl/wmiss_linereg.sv
module wmiss_linereg #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/wmiss_seq.sv
module wmiss_seq
  import wmiss_pkg::*;
#(
  parameter int TAG_W      = 20,
  parameter int IDX_W      = 14,
  parameter int LINE_BYTES = 64,
  localparam int LA_W   = TAG_W + IDX_W,
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_valid,
  output logic                  miss_ready,
  input  logic [LA_W-1:0]       miss_line_addr,
  input  logic [TAG_W-1:0]      miss_victim_tag,
  input  logic                  miss_victim_dirty,
  input  logic [LINE_W-1:0]     miss_victim_data,
  input  logic [LINE_W-1:0]     miss_store_data,
  input  logic [LINE_BYTES-1:0] miss_byte_en,
  output logic                  bus_req_valid,
  input  logic                  bus_req_ready,
  output logic                  bus_req_kind,
  output logic [LA_W-1:0]       bus_req_addr,
  output logic [LINE_W-1:0]     bus_req_data,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [LINE_W-1:0]     fill_data,
  output logic                  cwr_valid,
  input  logic                  cwr_ready,
  output logic [LA_W-1:0]       cwr_line_addr,
  output logic [LINE_W-1:0]     cwr_data,
  output logic [1:0]            cwr_line_state,
  output logic                  busy
);

  logic                  load_miss, load_fill;
  logic [LA_W-1:0]       line_addr_q;
  logic [TAG_W-1:0]      vtag_q;
  logic [LINE_W-1:0]     victim_q, store_q, merged_d, merged_q;
  logic [LINE_BYTES-1:0] be_q;
  logic [LA_W-1:0]       victim_addr;

  wmiss_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .victim_dirty  (miss_victim_dirty),
    .bus_req_ready (bus_req_ready),
    .fill_valid    (fill_valid),
    .cwr_ready     (cwr_ready),
    .miss_ready    (miss_ready),
    .bus_req_valid (bus_req_valid),
    .bus_req_kind  (bus_req_kind),
    .fill_ready    (fill_ready),
    .cwr_valid     (cwr_valid),
    .busy          (busy),
    .load_miss     (load_miss),
    .load_fill     (load_fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_addr_q <= '0;
      vtag_q      <= '0;
    end else if (load_miss) begin
      line_addr_q <= miss_line_addr;
      vtag_q      <= miss_victim_tag;
    end
  end

  wmiss_linereg #(.W(LINE_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .load(load_miss), .d(miss_victim_data), .q(victim_q));

  wmiss_linereg #(.W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load_miss), .d(miss_store_data), .q(store_q));

  wmiss_linereg #(.W(LINE_BYTES)) u_be (
    .clk(clk), .rst_n(rst_n), .load(load_miss), .d(miss_byte_en), .q(be_q));

  wmiss_bytemerge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .fill_line   (fill_data),
    .store_line  (store_q),
    .byte_en     (be_q),
    .merged_line (merged_d)
  );

  wmiss_linereg #(.W(LINE_W)) u_merged (
    .clk(clk), .rst_n(rst_n), .load(load_fill), .d(merged_d), .q(merged_q));

  assign victim_addr    = {vtag_q, line_addr_q[IDX_W-1:0]};
  assign bus_req_addr   = (bus_req_kind == REQ_WB) ? victim_addr : line_addr_q;
  assign bus_req_data   = victim_q;
  assign cwr_line_addr  = line_addr_q;
  assign cwr_data       = merged_q;
  assign cwr_line_state = LINE_ST_MOD;

  // R5
  req_payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> ($stable(bus_req_addr) && $stable(bus_req_data)));

  // R8
  cwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && !cwr_ready) |=>
      (cwr_valid && $stable(cwr_data) && $stable(cwr_line_addr)));

  // R9
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(line_addr_q));

endmodule

// File: tb/wmiss_seq_tb_top.sv
module wmiss_seq_tb_top;
  localparam int TAG_W = 20;
  localparam int IDX_W = 14;
  localparam int LB    = 64;
  localparam int LA_W  = TAG_W + IDX_W;
  localparam int LW    = 8 * LB;

  typedef struct {
    logic            kind;
    logic [LA_W-1:0] addr;
    logic [LW-1:0]   data;
  } bus_item_t;

  typedef struct {
    logic [LA_W-1:0] addr;
    logic [LW-1:0]   data;
  } cwr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic miss_ready;
  logic [LA_W-1:0]  miss_line_addr = '0;
  logic [TAG_W-1:0] miss_victim_tag = '0;
  logic             miss_victim_dirty = 1'b0;
  logic [LW-1:0]    miss_victim_data = '0;
  logic [LW-1:0]    miss_store_data = '0;
  logic [LB-1:0]    miss_byte_en = '0;
  logic bus_req_valid;
  logic bus_req_ready = 1'b0;
  logic bus_req_kind;
  logic [LA_W-1:0] bus_req_addr;
  logic [LW-1:0]   bus_req_data;
  logic fill_valid = 1'b0;
  logic fill_ready;
  logic [LW-1:0] fill_data = '0;
  logic cwr_valid;
  logic cwr_ready = 1'b0;
  logic [LA_W-1:0] cwr_line_addr;
  logic [LW-1:0]   cwr_data;
  logic [1:0]      cwr_line_state;
  logic busy;

  int n_checks = 0;
  int n_fail = 0;
  int rfo_cnt = 0;
  int fill_cnt = 0;
  int bp_mode = 0;  // 0 always ready, 1 random, 2 bus stalled
  bus_item_t bus_q[$];
  cwr_item_t cwr_q[$];
  logic [LW-1:0] fill_line = '0;

  always #10 clk = ~clk;

  wmiss_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line_addr(miss_line_addr), .miss_victim_tag(miss_victim_tag),
    .miss_victim_dirty(miss_victim_dirty), .miss_victim_data(miss_victim_data),
    .miss_store_data(miss_store_data), .miss_byte_en(miss_byte_en),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_kind(bus_req_kind), .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_data(fill_data),
    .cwr_valid(cwr_valid), .cwr_ready(cwr_ready), .cwr_line_addr(cwr_line_addr),
    .cwr_data(cwr_data), .cwr_line_state(cwr_line_state), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] v;
    for (int i = 0; i < LW / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // ready drivers and fill responder, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    case (bp_mode)
      0: begin bus_req_ready = 1'b1; cwr_ready = 1'b1; end
      1: begin bus_req_ready = ($urandom % 3) != 0; cwr_ready = ($urandom % 3) != 0; end
      default: begin bus_req_ready = 1'b0; cwr_ready = 1'b1; end
    endcase
    fill_valid = (rfo_cnt > fill_cnt);
    fill_data  = fill_line;
  end

  // monitor / scoreboard
  logic            p_bv = 1'b0, p_br = 1'b0, p_bk = 1'b0, p_cv = 1'b0, p_cr = 1'b0;
  logic [LA_W-1:0] p_ba = '0, p_ca = '0;
  logic [LW-1:0]   p_bd = '0, p_cd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_bv && !p_br) begin
        chk(bus_req_valid && bus_req_kind == p_bk && bus_req_addr == p_ba && bus_req_data == p_bd,
            "R5 request held under stall", LW'(bus_req_addr), LW'(p_ba));
      end
      if (p_cv && !p_cr) begin
        chk(cwr_valid && cwr_data == p_cd && cwr_line_addr == p_ca,
            "R8 cache write held under stall", cwr_data, p_cd);
      end
      if (fill_ready) chk(rfo_cnt > fill_cnt, "R6 fill_ready only after ownership read",
                          LW'(rfo_cnt), LW'(fill_cnt + 1));
      if (bus_req_valid || fill_ready || cwr_valid)
        chk(!miss_ready, "R9 miss_ready low while busy", LW'(miss_ready), '0);
      if (bus_req_valid && bus_req_ready) begin
        if (bus_q.size() == 0) begin
          chk(1'b0, "R9 unexpected bus request", LW'(bus_req_addr), '0);
        end else begin
          bus_item_t e;
          e = bus_q.pop_front();
          chk(bus_req_kind == e.kind, "R3/R4 request kind order", LW'(bus_req_kind), LW'(e.kind));
          chk(bus_req_addr == e.addr, e.kind ? "R4 ownership read address" : "R2 writeback address",
              LW'(bus_req_addr), LW'(e.addr));
          if (!e.kind) chk(bus_req_data == e.data, "R2 writeback data", bus_req_data, e.data);
          if (bus_req_kind) rfo_cnt++;
        end
      end
      if (fill_valid && fill_ready) fill_cnt++;
      if (cwr_valid && cwr_ready) begin
        if (cwr_q.size() == 0) begin
          chk(1'b0, "R9 unexpected cache write", LW'(cwr_line_addr), '0);
        end else begin
          cwr_item_t c;
          c = cwr_q.pop_front();
          chk(cwr_line_addr == c.addr, "R8 cache write address", LW'(cwr_line_addr), LW'(c.addr));
          chk(cwr_data == c.data, "R7/R10 merged line", cwr_data, c.data);
          chk(cwr_line_state == 2'b11, "R8 line state modified", LW'(cwr_line_state), LW'(2'b11));
        end
      end
      p_bv = bus_req_valid; p_br = bus_req_ready; p_bk = bus_req_kind;
      p_ba = bus_req_addr;  p_bd = bus_req_data;
      p_cv = cwr_valid; p_cr = cwr_ready; p_ca = cwr_line_addr; p_cd = cwr_data;
    end
  end

  // driver: pushes expected items, then presents the miss
  task automatic do_miss(input logic [LA_W-1:0] addr, input logic [TAG_W-1:0] vtag,
                         input logic dirty, input logic [LB-1:0] be, input bit intrude);
    bus_item_t b;
    cwr_item_t c;
    logic [LW-1:0] vdata, sdata, fdata;
    vdata = rand_line(); sdata = rand_line(); fdata = rand_line();
    if (dirty) begin
      b.kind = 1'b0; b.addr = {vtag, addr[IDX_W-1:0]}; b.data = vdata;
      bus_q.push_back(b);
    end
    b.kind = 1'b1; b.addr = addr; b.data = '0;
    bus_q.push_back(b);
    c.addr = addr;
    for (int i = 0; i < LB; i++) c.data[8*i +: 8] = be[i] ? sdata[8*i +: 8] : fdata[8*i +: 8];
    cwr_q.push_back(c);
    fill_line = fdata;
    @(negedge clk);
    miss_line_addr = addr; miss_victim_tag = vtag; miss_victim_dirty = dirty;
    miss_victim_data = vdata; miss_store_data = sdata; miss_byte_en = be;
    miss_valid = 1'b1;
    while (!miss_ready) @(negedge clk);
    @(posedge clk);
    #1 miss_valid = 1'b0;
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        miss_line_addr = ~addr; miss_victim_dirty = 1'b1; miss_valid = 1'b1;
        chk(!miss_ready, "R9 miss refused while busy", LW'(miss_ready), '0);
      end
      @(posedge clk);
      #1 miss_valid = 1'b0;
      bp_mode = 0;
    end
    while (bus_q.size() != 0 || cwr_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(miss_ready && !busy, "R9 idle after cache write", LW'(miss_ready), LW'(1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1 miss_ready at reset", LW'(miss_ready), LW'(1));
    chk(!busy && !bus_req_valid && !fill_ready && !cwr_valid, "R1 outputs idle at reset",
        LW'({busy, bus_req_valid, fill_ready, cwr_valid}), '0);
    // R2 dirty victim, R3 clean victim
    do_miss(34'h0_1234_5678, 20'hABCDE, 1'b1, {2{32'h0F0F_3C3C}}, 1'b0);
    do_miss(34'h1_0000_0001, 20'h11111, 1'b0, {2{32'hFFFF_0000}}, 1'b0);
    // R10 full and empty masks
    do_miss(34'h2_2222_2222, 20'h33333, 1'b1, '1, 1'b0);
    do_miss(34'h3_3333_3333, 20'h44444, 1'b0, '0, 1'b0);
    // R9 miss presented while stalled on the bus
    bp_mode = 2;
    do_miss(34'h0_5555_AAAA, 20'h55555, 1'b1, {2{32'h8000_0001}}, 1'b1);
    // R5 random back-pressure
    bp_mode = 1;
    for (int n = 0; n < 16; n++) begin
      do_miss(LA_W'({$urandom, $urandom}), TAG_W'($urandom), 1'($urandom),
              {$urandom, $urandom}, 1'b0);
    end
    bp_mode = 0;
    repeat (4) @(negedge clk);
    chk(bus_q.size() == 0 && cwr_q.size() == 0, "R4 all expected items seen",
        LW'(bus_q.size() + cwr_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule